// File: doc/BRIEF.md
# Staggered Multi-Converter Read Sequencer

This block drives a bank of identical serial converters so that their conversions overlap in time. The combined sample rate is the single-converter rate multiplied by the number of converters. Each converter has its own active-low select line. All converters share one serial clock and one serial data line. A phase timer splits one conversion period into equal slots, one slot per converter. At the start of each slot the block lowers that converter's select, clocks out the result the converter finished during the previous period, and raises the select again. That rising edge restarts the converter's conversion, so the restart instants are spread evenly across the period.

Each completed read produces a data word, the index of the converter it came from, a one-cycle valid strobe and a stale marker. The stale marker flags the first read of each converter after reset, because that converter had not yet converted anything. The select lines are never low together, so only one converter drives the shared data line at any time. If a slot starts while the previous read is still in progress, that slot is skipped and a sticky overrun flag is raised. The number of converters, the conversion period in system clocks, the read length and the serial clock half-period are all parameters.

Top module: `ilv_conv_sequencer`

## Requirements
- R1: While reset is held and in the cycle after it is released, all selects are high, the serial clock is low, and valid and overrun are 0.
- R2: At most one select line is low at any time.
- R3: Reads visit converters in the order 0, 1, …, NUM_CONV-1 and then repeat. Consecutive select rising edges are CONV_PERIOD_CLKS/NUM_CONV system clocks apart, which is 100 with the default parameters.
- R4: Every read applies exactly READ_BITS rising serial-clock edges, and READ_BITS must be between 2 and 23. Each serial-clock half-period lasts SCK_HALF_CLKS system clocks, and the serial clock stays low whenever no select is low.
- R5: The shared data line is sampled on each rising serial-clock edge. The first bit sampled becomes the most significant bit of the data word.
- R6: Valid is a one-cycle pulse, asserted in the cycle after the select rises, with all selects high. The converter index (width $clog2(NUM_CONV)) names the converter that was just read, and it follows the order 0, 1, 2, 3, 0, … when no overrun occurs.
- R7: The stale marker is 1 on the first read of each converter after reset and 0 on every later read of that converter.
- R8: When a slot starts while a read is still in progress, overrun is set and stays at 1 until reset. That slot's converter is not selected, and the next free slot proceeds normally.
- R9: The converter count is a parameter. A bank of three converters follows the same sequencing and skipping rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdo_i | input | 1 | Shared serial data from the converters |
| sck_o | output | 1 | Shared serial clock |
| cs_n_o | output | NUM_CONV | Per-converter active-low select |
| data_o | output | READ_BITS | Word from the last read |
| conv_idx_o | output | $clog2(NUM_CONV) | Converter the word came from |
| stale_o | output | 1 | First read of this converter since reset |
| valid_o | output | 1 | One-cycle strobe marking a new word |
| overrun_o | output | 1 | Sticky: a slot began while a read was in progress |

## Verification
The assertions assume that the data line is meaningful only while a select is low. They also assume that any parameter set which lets a read outrun its slot is caught through the overrun flag, not through the order check. For that reason, the check on index order is suspended once overrun is set. The bench converter models drive the shared line only while their own select is low. Each model presents its most significant bit when its select falls, shifts on each falling serial-clock edge, and takes a new result on each select rise. A second instance, with three converters and a slot too short for a read, is tied to a quiet data line and exercises the skip path.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // system clocks between successive slot starts
  function automatic int slot_clks(input int period_clks, input int n_conv);
    return period_clks / n_conv;
  endfunction

  // system clocks from select fall to select rise for one read
  function automatic int read_clks(input int n_bits, input int half_clks);
    return 2 * n_bits * half_clks;
  endfunction
endpackage

// File: rtl/ilv_phase_timer.sv
module ilv_phase_timer #(
  parameter int NUM_CONV  = 4,
  parameter int SLOT_CLKS = 100,
  parameter int IW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          start_o,
  output logic [IW-1:0] slot_idx_o
);
  localparam int CW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic [CW-1:0] phase_q;
  logic [IW-1:0] slot_q;
  logic          wrap;

  assign wrap       = (phase_q == CW'(SLOT_CLKS - 1));
  assign start_o    = (phase_q == '0);
  assign slot_idx_o = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      slot_q  <= '0;
    end else if (wrap) begin
      phase_q <= '0;
      slot_q  <= (slot_q == IW'(NUM_CONV - 1)) ? '0 : slot_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // the slot index may only move in a cycle that opens a slot
  assert_slot_moves_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_q) |-> start_o);
endmodule

// File: rtl/ilv_serial_reader.sv
module ilv_serial_reader #(
  parameter int NUM_CONV  = 4,
  parameter int READ_BITS = 23,
  parameter int HALF_CLKS = 2,
  parameter int IW        = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [IW-1:0]        idx_i,
  input  logic                 sdo_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 sck_o,
  output logic [NUM_CONV-1:0]  cs_n_o,
  output logic [READ_BITS-1:0] word_o,
  output logic [IW-1:0]        idx_o
);
  localparam int DW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam int BW = $clog2(READ_BITS + 1);

  logic                 busy_q, sck_q, done_q;
  logic [DW-1:0]        div_q;
  logic [BW-1:0]        bit_q;
  logic [READ_BITS-1:0] sh_q;
  logic [IW-1:0]        idx_q;

  // named events for the assertions
  logic half_end, rise_evt, fall_evt, last_fall;
  assign half_end  = busy_q && (div_q == DW'(HALF_CLKS - 1));
  assign rise_evt  = half_end && !sck_q;
  assign fall_evt  = half_end && sck_q;
  assign last_fall = fall_evt && (bit_q == BW'(READ_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      idx_q  <= '0;
    end else begin
      done_q <= last_fall;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        idx_q  <= idx_i;
        div_q  <= '0;
        bit_q  <= '0;
        sck_q  <= 1'b0;
        sh_q   <= '0;
      end else if (busy_q) begin
        div_q <= half_end ? '0 : div_q + 1'b1;
        if (half_end)  sck_q  <= ~sck_q;
        if (rise_evt)  sh_q   <= {sh_q[READ_BITS-2:0], sdo_i};
        if (fall_evt)  bit_q  <= bit_q + 1'b1;
        if (last_fall) busy_q <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < NUM_CONV; k++) begin : g_cs
    assign cs_n_o[k] = !(busy_q && (idx_q == IW'(k)));
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sck_o  = sck_q;
  assign word_o = sh_q;
  assign idx_o  = idx_q;

  initial begin
    assert_read_len_legal_R4: assert (READ_BITS >= 2 && READ_BITS <= 23);
  end

  assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_no_sample_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(sh_q) || $past(start_i));
endmodule

// File: rtl/ilv_conv_sequencer.sv
module ilv_conv_sequencer #(
  parameter int NUM_CONV         = 4,
  parameter int CONV_PERIOD_CLKS = 400,
  parameter int READ_BITS        = 23,
  parameter int SCK_HALF_CLKS    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sdo_i,
  output logic                         sck_o,
  output logic [NUM_CONV-1:0]          cs_n_o,
  output logic [READ_BITS-1:0]         data_o,
  output logic [$clog2(NUM_CONV)-1:0]  conv_idx_o,
  output logic                         stale_o,
  output logic                         valid_o,
  output logic                         overrun_o
);
  localparam int IW        = $clog2(NUM_CONV);
  localparam int SLOT_CLKS = ilv_pkg::slot_clks(CONV_PERIOD_CLKS, NUM_CONV);

  logic          slot_start, rd_busy, rd_done;
  logic [IW-1:0] slot_idx, rd_idx;
  logic [NUM_CONV-1:0] seen_q;
  logic          overrun_q;
  logic          slot_clash;

  ilv_phase_timer #(.NUM_CONV(NUM_CONV), .SLOT_CLKS(SLOT_CLKS), .IW(IW)) timer_i (
    .clk(clk), .rst_n(rst_n), .start_o(slot_start), .slot_idx_o(slot_idx));

  ilv_serial_reader #(.NUM_CONV(NUM_CONV), .READ_BITS(READ_BITS),
                      .HALF_CLKS(SCK_HALF_CLKS), .IW(IW)) reader_i (
    .clk(clk), .rst_n(rst_n), .start_i(slot_start), .idx_i(slot_idx), .sdo_i(sdo_i),
    .busy_o(rd_busy), .done_o(rd_done), .sck_o(sck_o), .cs_n_o(cs_n_o),
    .word_o(data_o), .idx_o(rd_idx));

  assign slot_clash = slot_start && rd_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q    <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (rd_done)    seen_q[rd_idx] <= 1'b1;
      if (slot_clash) overrun_q      <= 1'b1;
    end
  end

  assign valid_o    = rd_done;
  assign conv_idx_o = rd_idx;
  assign stale_o    = !seen_q[rd_idx];
  assign overrun_o  = overrun_q;

  // checker-side expectation of the next converter index
  logic [IW-1:0] chk_idx_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       chk_idx_q <= '0;
    else if (valid_o) chk_idx_q <= (rd_idx == IW'(NUM_CONV - 1)) ? '0 : rd_idx + 1'b1;
  end

  assert_idx_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !overrun_q |-> conv_idx_o == chk_idx_q);

  assert_valid_bus_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> &cs_n_o);

  assert_overrun_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_clash |=> overrun_o);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  assert_single_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n_o) <= 1);
endmodule

// File: tb/ilv_conv_sequencer_tb.sv
module ilv_conv_sequencer_tb_top;
  localparam int NC = 4;
  localparam int NB = 23;
  localparam int SPACING = 400 / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  logic          sdo, sck;
  logic [NC-1:0] cs_n;
  logic [NB-1:0] data;
  logic [1:0]    idx;
  logic          stale, valid, ovr;

  logic [2:0]  cs2_n;
  logic [NB-1:0] data2;
  logic [1:0]  idx2;
  logic        sck2, stale2, valid2, ovr2;

  ilv_conv_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .sdo_i(sdo), .sck_o(sck), .cs_n_o(cs_n),
    .data_o(data), .conv_idx_o(idx), .stale_o(stale), .valid_o(valid), .overrun_o(ovr));

  // three converters, slot of 60 clocks is shorter than a 92-clock read
  ilv_conv_sequencer #(.NUM_CONV(3), .CONV_PERIOD_CLKS(180)) dut2_i (
    .clk(clk), .rst_n(rst_n), .sdo_i(1'b0), .sck_o(sck2), .cs_n_o(cs2_n),
    .data_o(data2), .conv_idx_o(idx2), .stale_o(stale2), .valid_o(valid2), .overrun_o(ovr2));

  function automatic logic [NB-1:0] conv_word(input int k, input int n);
    return NB'((k + 1) * 32'h2B1C5 + n * 32'h3A7) ^ NB'(n << 11);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter models: MSB shown at select fall, shift on sck fall
  logic [NC-1:0] mbit;
  for (genvar k = 0; k < NC; k++) begin : g_conv
    logic [NB-1:0] shr;
    int n_rd = 0;
    always @(negedge cs_n[k]) shr = conv_word(k, n_rd);
    always @(posedge cs_n[k]) if (rst_n) n_rd++;
    always @(negedge sck) if (!cs_n[k]) shr = shr << 1;
    assign mbit[k] = shr[NB-1] & ~cs_n[k];
  end
  assign sdo = |mbit;

  // bus monitor
  int  sck_rises = 0;
  bit  overlap = 1'b0, idle_clk = 1'b0;
  logic [NC-1:0] cs_prev = '1;
  always @(posedge sck) sck_rises++;
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(~cs_n) > 1 || $countones(~cs2_n) > 1) overlap = 1'b1;
      if (&cs_n && sck) idle_clk = 1'b1;
      if (&cs_prev && !(&cs_n)) sck_rises = 0;
      if (!(&cs_prev) && &cs_n)
        check(sck_rises == NB, "R4 sck pulses per read", sck_rises, NB);
    end
    cs_prev = cs_n;
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(&cs_n && &cs2_n, "R1 selects high in reset", cs_n, 4'hF);
    check(!sck && !valid && !ovr, "R1 sck/valid/overrun low in reset",
          {sck, valid, ovr}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(!valid && !ovr && !sck, "R1 quiet after release", {sck, valid, ovr}, 0);
  endtask

  task automatic t_interleave(input int n_reads);
    int last = 0;
    for (int r = 0; r < n_reads; r++) begin
      int k = r % NC;
      int n = r / NC;
      do @(negedge clk); while (!valid);
      check(idx == 2'(k), "R6 index order", idx, k);
      check(data == conv_word(k, n), "R5 data word MSB first", data, conv_word(k, n));
      check(stale == (n == 0), "R7 stale marker", stale, (n == 0));
      check(&cs_n, "R6 valid with bus released", cs_n, 4'hF);
      if (r > 0) check(cyc - last == SPACING, "R3 slot spacing", cyc - last, SPACING);
      last = cyc;
      @(negedge clk);
      check(!valid, "R6 valid lasts one cycle", valid, 0);
    end
    check(!ovr, "R8 no overrun when read fits", ovr, 0);
  endtask

  task automatic t_overrun();
    int seen_idx[2];
    int got = 0;
    while (got < 2) begin
      @(negedge clk);
      if (valid2) begin
        seen_idx[got] = idx2;
        got++;
      end
    end
    check(ovr2, "R8 overrun raised on slot clash", ovr2, 1);
    check(seen_idx[0] == 0, "R9 three-converter first read", seen_idx[0], 0);
    check(seen_idx[1] == 2, "R8 busy slot skipped", seen_idx[1], 2);
    repeat (20) @(negedge clk);
    check(ovr2, "R8 overrun sticky", ovr2, 1);
  endtask

  task automatic t_bus_rules();
    check(!overlap, "R2 one select low at a time", overlap, 0);
    check(!idle_clk, "R4 sck idle low", idle_clk, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    fork
      t_interleave(12);
      t_overrun();
    join
    t_bus_rules();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule